// File: doc/BRIEF.md
# Carry-Skip Adder

This block adds two unsigned or two's-complement operands and an incoming carry in one combinational pass. The operand width is divided into equal groups. Inside each group the carry ripples bit by bit, but every group also has a skip path. When each bit of a group would pass its incoming carry straight through, a two-input multiplexer forwards the group's carry-in directly to the next group.

Bit-level propagate and generate terms are formed for all bits at once. The muxed carry of each group drives the next group's carry-in, and the muxed carry of the top group is the block's carry output. With the default configuration of 16 bits in four groups of four, the longest carry path ripples through the lowest group, skips the two middle groups and ripples through the highest one. The delay grows with twice the group length plus one skip step per extra group, instead of with the full width. The block has no state and holds no clock.

Top module: `csa_skip_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_out} equals opnd_a + opnd_b + carry_in taken as a (WIDTH+1)-bit unsigned sum. With all inputs zero, both outputs are zero.
- R2: When opnd_a XOR opnd_b is all ones and carry_in is 1, every group takes its skip path, sum_out is 0x0000 and carry_out is 1 (for example 0xFFFF + 0x0000 + 1).
- R3: When opnd_a XOR opnd_b is all ones and carry_in is 0, sum_out equals opnd_a XOR opnd_b (0xFFFF) and carry_out is 0.
- R4: A carry generated in bit 0 reaches carry_out across fully propagating upper groups: 0x0001 + 0xFFFF with carry_in 0 gives sum 0x0000 and carry_out 1.
- R5: A carry that starts inside a group that does not skip ripples into the following bits: 0x000F + 0x0001 gives 0x0010, and 0x0FF0 + 0x0010 gives 0x1000, both with carry_out 0.
- R6: A carry generated in the most significant bit appears on carry_out: 0x8000 + 0x8000 gives sum 0x0000 and carry_out 1.
- R7: The group size GROUP is a parameter that must divide WIDTH. The 16-bit adder built with groups of 2 and of 8 gives the same sum_out and carry_out as the default build for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (16) | First operand |
| opnd_b | input | WIDTH (16) | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Sum bits |
| carry_out | output | 1 | Muxed carry out of the top group |

## Verification
The assertions are immediate checks that are evaluated whenever the combinational outputs settle. They assume that the operands and carry-in are steady, known two-state values while a result is examined. The bench changes the inputs only once per bench cycle, just after the rising edge. It compares the outputs at the following falling edge, so every assertion and every check sees one stable input set. The directed vectors concentrate on all-propagate patterns, where the skip path and the ripple path must agree.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Per-bit carry terms.
    typedef struct packed {
        logic p;   // carry passes through this bit
        logic g;   // this bit creates a carry on its own
    } pg_bit_t;

    function automatic pg_bit_t make_pg(input logic a, input logic b);
        pg_bit_t r;
        r.p = a ^ b;
        r.g = a & b;
        return r;
    endfunction

    function automatic logic next_carry(input pg_bit_t x, input logic c);
        return x.g | (x.p & c);
    endfunction

    function automatic logic sum_of(input pg_bit_t x, input logic c);
        return x.p ^ c;
    endfunction

endpackage

// File: rtl/csa_pg_gen.sv
module csa_pg_gen
    import csa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    b_i,
    output pg_bit_t [WIDTH-1:0] pg_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg_o[i] = make_pg(a_i[i], b_i[i]);
    end

endmodule

// File: rtl/csa_ripple_group.sv
module csa_ripple_group
    import csa_pkg::*;
#(
    parameter int GROUP = 4
) (
    input  pg_bit_t [GROUP-1:0] pg_i,
    input  logic                c_in,
    output logic [GROUP-1:0]    sum_o,
    output logic                c_ripple_o,
    output logic                skip_o
);

    logic [GROUP:0]   chain;
    logic [GROUP-1:0] prop_vec;

    assign chain[0] = c_in;

    for (genvar i = 0; i < GROUP; i++) begin : g_stage
        assign prop_vec[i]  = pg_i[i].p;
        assign sum_o[i]     = sum_of(pg_i[i], chain[i]);
        assign chain[i+1]   = next_carry(pg_i[i], chain[i]);
    end

    assign c_ripple_o = chain[GROUP];
    assign skip_o     = &prop_vec;

    // Skipping is safe only if the ripple chain would give the same carry.
    always_comb begin
        if (skip_o) begin
            assert_skip_matches_ripple_R2: assert (c_ripple_o == c_in)
                else $error("skip taken but ripple carry differs");
            assert_skip_sum_inverts_R3: assert (sum_o == {GROUP{~c_in}})
                else $error("all-propagate group sum not inverse of carry-in");
        end
    end

endmodule

// File: rtl/csa_skip_mux.sv
module csa_skip_mux (
    input  logic c_in,
    input  logic c_ripple,
    input  logic skip,
    output logic c_out
);

    assign c_out = skip ? c_in : c_ripple;

endmodule

// File: rtl/csa_skip_adder.sv
module csa_skip_adder
    import csa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NGRP = WIDTH / GROUP;

    if ((WIDTH % GROUP) != 0) begin : g_bad_cfg
        $error("GROUP must divide WIDTH");
    end

    pg_bit_t [WIDTH-1:0] pg;
    logic    [NGRP:0]    gcarry;
    logic    [NGRP-1:0]  rip_c;
    logic    [NGRP-1:0]  skip;

    csa_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a_i  (opnd_a),
        .b_i  (opnd_b),
        .pg_o (pg)
    );

    assign gcarry[0] = carry_in;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        csa_ripple_group #(.GROUP(GROUP)) u_grp (
            .pg_i       (pg[k*GROUP +: GROUP]),
            .c_in       (gcarry[k]),
            .sum_o      (sum_out[k*GROUP +: GROUP]),
            .c_ripple_o (rip_c[k]),
            .skip_o     (skip[k])
        );

        csa_skip_mux u_mux (
            .c_in     (gcarry[k]),
            .c_ripple (rip_c[k]),
            .skip     (skip[k]),
            .c_out    (gcarry[k+1])
        );
    end

    assign carry_out = gcarry[NGRP];

    always_comb begin
        assert_sum_exact_R1: assert ({carry_out, sum_out} ==
            ({1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("adder result differs from arithmetic sum");
        if (&skip) begin
            assert_full_skip_carry_R2: assert (carry_out == carry_in)
                else $error("all groups skip but carry_out differs from carry_in");
        end
    end

endmodule

// File: tb/csa_skip_adder_test.sv
module csa_skip_adder_test;

    localparam int  W        = 16;
    localparam time CLK_HALF = 5ns;
    localparam time CLK_PER  = 2 * CLK_HALF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         ci = 1'b0;
    logic [W-1:0] s4, s2, s8;
    logic         co4, co2, co8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_HALF) clk = ~clk;

    csa_skip_adder #(.WIDTH(W), .GROUP(4)) uut (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum_out(s4), .carry_out(co4));
    csa_skip_adder #(.WIDTH(W), .GROUP(2)) uut_m2 (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum_out(s2), .carry_out(co2));
    csa_skip_adder #(.WIDTH(W), .GROUP(8)) uut_m8 (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum_out(s8), .carry_out(co8));

    task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        a  = va;
        b  = vb;
        ci = vc;
        it.exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: one comparison per bench cycle, at the falling edge.
    always @(negedge clk) begin
        item_t it;
        if (!rst && sb_q.size() != 0) begin
            it = sb_q.pop_front();
            checks++;
            if ({co4, s4} !== it.exp) begin
                fails++;
                $display("FAIL %s: got %h expected %h", it.tag, {co4, s4}, it.exp);
            end
            checks++;
            if ({co2, s2} !== it.exp || {co8, s8} !== it.exp) begin
                fails++;
                $display("FAIL R7: got m2=%h m8=%h expected %h",
                         {co2, s2}, {co8, s8}, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 1'b0, "R1 zero after reset");
        drive(16'hFFFF, 16'h0000, 1'b1, "R2 full skip cin1");
        drive(16'hA5A5, 16'h5A5A, 1'b1, "R2 full skip mixed cin1");
        drive(16'hFFFF, 16'h0000, 1'b0, "R3 full skip cin0");
        drive(16'h0F0F, 16'hF0F0, 1'b0, "R3 full skip mixed cin0");
        drive(16'h0001, 16'hFFFF, 1'b0, "R4 carry from bit0 over skipped groups");
        drive(16'hFFFE, 16'h0001, 1'b1, "R4 cin through all groups");
        drive(16'h000F, 16'h0001, 1'b0, "R5 ripple out of group0");
        drive(16'h0FF0, 16'h0010, 1'b0, "R5 ripple across two groups");
        drive(16'h8000, 16'h8000, 1'b0, "R6 top bit generate");
        drive(16'h7FFF, 16'h7FFF, 1'b1, "R1 large operands");
        for (int i = 0; i < W; i++) begin
            drive(16'(1) << i, 16'hFFFF, 1'b0, "R1 walking one");
        end
        for (int i = 0; i < 400; i++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
        end
        while (sb_q.size() != 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule